// File: doc/BRIEF.md
# Step attenuator control interface

This block is the digital front end of a 6-bit step attenuator whose setting is counted in half-decibel units. It accepts either a parallel control word on six pins or a word shifted in bit by bit over a data/clock pair. It presents one registered attenuation code to the switch array. A latch-enable input decides when the code follows its source and when it is frozen. A mode pin chooses the source: low for the parallel pins, high for the shift register.

Power-up is modelled as the release of a synchronous reset. On the first cycle after release, the block loads a starting code before any control word has been given. In parallel mode with latch-enable low, two select pins pick the code from a table of four preset levels. In every other power-up case the code is taken from the parallel pins. The serial clock, serial data and latch-enable are asynchronous to the system clock, so they pass through a synchroniser chain. The mode, select and parallel pins are treated as static or synchronous.

Top module: `step_atten_ctrl`

## Requirements
- R1: While reset is high, the code output is 0 after the next clock edge.
- R2: In the first cycle after reset release, with the mode pin low and latch-enable low, the code is loaded from the select pins (bit 1 is the MSB). 00 gives code 0, 01 gives code 16 (8 dB), 10 gives code 32 (16 dB) and 11 gives code 62 (31 dB).
- R3: In the first cycle after reset release, with the mode pin low and latch-enable high, the code is the parallel pins and the select pins have no effect.
- R4: In the first cycle after reset release, with the mode pin high, the code is the parallel pins.
- R5: Each rising edge of the synchronised serial clock shifts the synchronised data bit into bit 0 of a 6-bit register and moves the older bits toward bit 5. The first bit sent therefore ends as the MSB (16 dB weight). Shifting takes place whatever the level of latch-enable.
- R6: After the power-up cycle, while the synchronised latch-enable is low, the code holds its value whatever the parallel, serial or select pins do.
- R7: In direct parallel mode (mode pin low, latch-enable high), the code takes the value on the parallel pins one clock later.
- R8: In latched parallel mode, a new value set on the parallel pins while latch-enable is low is applied by a high-then-low pulse on latch-enable. The pulse lasts at least one clock.
- R9: The select pins are read only in the power-up cycle; changing them afterwards does not change the code.
- R10: While the synchronised latch-enable is high, the code follows the shift register when the mode pin is high and the parallel pins when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up model) |
| mode_serial_i | input | 1 | 0 = parallel source, 1 = serial source |
| par_code_i | input | 6 | Parallel attenuation word, bit 5 = 16 dB, bit 0 = 0.5 dB |
| sdata_i | input | 1 | Serial data, asynchronous |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| latch_en_i | input | 1 | Latch enable, asynchronous, high = transparent |
| boot_sel_i | input | 2 | Power-up preset select, bit 1 is MSB |
| code_o | output | 6 | Registered attenuation code in 0.5 dB steps |

## Verification
The power-up choice is the hardest case to reach, because it is decided in a single cycle and never again. The bench therefore runs the reset sequence again for each entry of the preset table and for each mode and latch-enable combination, with the pins set up before release. The effect of each preset is then seen through the hold state that follows. It also drives a full serial word with latch-enable low, to show that the register loads while the output does not move. The word appears only after a latch pulse. A later load with latch-enable high shows the output moving with the shifts.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int unsigned ATTEN_W     = 6;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned SEL_W       = 2;

  typedef enum logic [1:0] {
    SYNC_SCLK  = 2'd0,
    SYNC_SDATA = 2'd1,
    SYNC_LE    = 2'd2
  } sync_idx_e;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = atten_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
  parameter int unsigned CODE_W = atten_pkg::ATTEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [CODE_W-1:0] word_o
);
  logic [CODE_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (shift_en) begin
      sreg <= {sreg[CODE_W-2:0], bit_in};
    end
  end

  assign word_o = sreg;
endmodule

// File: rtl/atten_boot.sv
module atten_boot #(
  parameter int unsigned CODE_W = atten_pkg::ATTEN_W,
  parameter int unsigned SEL_W  = atten_pkg::SEL_W
) (
  input  logic              mode_serial,
  input  logic              le_raw,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CODE_W-1:0] par_code,
  output logic [CODE_W-1:0] boot_code
);
  localparam logic [CODE_W-1:0] PRESET_0 = '0;
  localparam logic [CODE_W-1:0] PRESET_1 = CODE_W'(1 << (CODE_W-2));
  localparam logic [CODE_W-1:0] PRESET_2 = CODE_W'(1 << (CODE_W-1));
  localparam logic [CODE_W-1:0] PRESET_3 = CODE_W'((1 << CODE_W) - 2);

  logic [CODE_W-1:0] preset;

  always_comb begin
    case (sel)
      2'b00:   preset = PRESET_0;
      2'b01:   preset = PRESET_1;
      2'b10:   preset = PRESET_2;
      default: preset = PRESET_3;
    endcase
  end

  always_comb begin
    if (!mode_serial && !le_raw) boot_code = preset;
    else                         boot_code = par_code;
  end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int unsigned CODE_W = atten_pkg::ATTEN_W,
  parameter int unsigned SEL_W  = atten_pkg::SEL_W,
  parameter int unsigned STAGES = atten_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_serial_i,
  input  logic [CODE_W-1:0] par_code_i,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              latch_en_i,
  input  logic [SEL_W-1:0]  boot_sel_i,
  output logic [CODE_W-1:0] code_o
);
  import atten_pkg::*;

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0]  async_in;
  logic [NSYNC-1:0]  sync_out;
  logic              sclk_s, sdata_s, le_s;
  logic              sclk_prev;
  logic              shift_en;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] boot_code;
  logic [CODE_W-1:0] code_q;
  logic              boot_done;

  always_comb begin
    async_in             = '0;
    async_in[SYNC_SCLK]  = sclk_i;
    async_in[SYNC_SDATA] = sdata_i;
    async_in[SYNC_LE]    = latch_en_i;
  end

  atten_sync #(.WIDTH(NSYNC), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (async_in),
    .q_o (sync_out)
  );

  assign sclk_s  = sync_out[SYNC_SCLK];
  assign sdata_s = sync_out[SYNC_SDATA];
  assign le_s    = sync_out[SYNC_LE];

  assign shift_en = sclk_s & ~sclk_prev;

  atten_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (sdata_s),
    .word_o   (shreg)
  );

  atten_boot #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_boot (
    .mode_serial (mode_serial_i),
    .le_raw      (latch_en_i),
    .sel         (boot_sel_i),
    .par_code    (par_code_i),
    .boot_code   (boot_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      boot_done <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      if (!boot_done) begin
        code_q    <= boot_code;
        boot_done <= 1'b1;
      end else if (le_s) begin
        code_q <= mode_serial_i ? shreg : par_code_i;
      end
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/atten_ctrl_checker.sv
module atten_ctrl_checker #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_serial_i,
  input logic [CODE_W-1:0] par_code_i,
  input logic              latch_en_i,
  input logic [SEL_W-1:0]  boot_sel_i,
  input logic [CODE_W-1:0] code_o,
  input logic              le_s,
  input logic              sdata_s,
  input logic              shift_en,
  input logic [CODE_W-1:0] shreg,
  input logic              boot_done
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (code_o == '0));

  assert_boot_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!boot_done && !mode_serial_i && !latch_en_i && boot_sel_i == 2'b00) |=> (code_o == '0));

  assert_boot_top_R2: assert property (@(posedge clk) disable iff (rst)
    (!boot_done && !mode_serial_i && !latch_en_i && boot_sel_i == 2'b11)
      |=> (code_o == CODE_W'((1 << CODE_W) - 2)));

  assert_shift_order_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (shreg == {$past(shreg[CODE_W-2:0]), $past(sdata_s)}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (boot_done && !le_s) |=> $stable(code_o));

  assert_direct_R7: assert property (@(posedge clk) disable iff (rst)
    (boot_done && le_s && !mode_serial_i) |=> (code_o == $past(par_code_i)));

  assert_serial_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (boot_done && le_s && mode_serial_i) |=> (code_o == $past(shreg)));
endmodule

bind step_atten_ctrl atten_ctrl_checker #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_serial_i (mode_serial_i),
  .par_code_i    (par_code_i),
  .latch_en_i    (latch_en_i),
  .boot_sel_i    (boot_sel_i),
  .code_o        (code_o),
  .le_s          (le_s),
  .sdata_s       (sdata_s),
  .shift_en      (shift_en),
  .shreg         (shreg),
  .boot_done     (boot_done)
);

// File: tb/step_atten_ctrl_bench.sv
module step_atten_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode = 1'b0;
  logic [W-1:0] par = '0;
  logic         sdata = 1'b0;
  logic         sclk = 1'b0;
  logic         le = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] code;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_atten_ctrl u_step_atten_ctrl (
    .clk           (clk),
    .rst           (rst),
    .mode_serial_i (mode),
    .par_code_i    (par),
    .sdata_i       (sdata),
    .sclk_i        (sclk),
    .latch_en_i    (le),
    .boot_sel_i    (sel),
    .code_o        (code)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sb[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  task automatic expect_code(input logic [W-1:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: pops expectations and compares away from the active edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (code !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%0d expected=%0d", it.tag, code, it.exp);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boot(input logic m, input logic l, input logic [1:0] s, input logic [W-1:0] p);
    @(negedge clk);
    rst = 1'b1;
    mode = m; le = l; sel = s; par = p; sclk = 1'b0; sdata = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(5);
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W-1; i >= 0; i--) begin
      sdata = w[i];
      idle(3);
      sclk = 1'b1;
      idle(3);
      sclk = 1'b0;
      idle(3);
    end
  endtask

  task automatic pulse_le();
    le = 1'b1;
    idle(4);
    le = 1'b0;
    idle(4);
  endtask

  initial begin
    // R1: reset state
    rst = 1'b1; mode = 1'b0; le = 1'b0; sel = 2'b01; par = 6'h2A;
    idle(4);
    expect_code(6'd0, "R1 reset");
    rst = 1'b0;
    idle(5);
    expect_code(6'd16, "R2 preset 01");
    // R6: hold while latch low
    par = 6'h11;
    idle(6);
    expect_code(6'd16, "R6 hold parallel change");
    // R9: select pins ignored after power-up
    sel = 2'b11;
    idle(6);
    expect_code(6'd16, "R9 select change after boot");
    // R8: latched parallel pulse
    pulse_le();
    expect_code(6'h11, "R8 latch pulse");

    boot(1'b0, 1'b0, 2'b00, 6'h3F);
    expect_code(6'd0, "R2 preset 00");
    boot(1'b0, 1'b0, 2'b10, 6'h3F);
    expect_code(6'd32, "R2 preset 10");
    boot(1'b0, 1'b0, 2'b11, 6'h01);
    expect_code(6'd62, "R2 preset 11");

    // R3: latch high at power-up uses parallel pins
    boot(1'b0, 1'b1, 2'b11, 6'd5);
    expect_code(6'd5, "R3 boot latch high");
    // R7: direct parallel
    par = 6'h3F;
    idle(2);
    expect_code(6'h3F, "R7 direct change");
    par = 6'h00;
    idle(2);
    expect_code(6'h00, "R7 direct zero");
    le = 1'b0;
    idle(4);

    // R4: serial power-up from parallel pins
    boot(1'b1, 1'b0, 2'b01, 6'h27);
    expect_code(6'h27, "R4 serial boot");
    // R5/R6: load with latch low, output holds
    shift_word(6'h0C);
    expect_code(6'h27, "R6 hold during serial load");
    pulse_le();
    expect_code(6'h0C, "R5 msb-first word after latch");
    // R5/R10: shift with latch high, output follows register
    le = 1'b1;
    idle(4);
    shift_word(6'h33);
    expect_code(6'h33, "R10 serial follow with latch high");
    // R10: mode switch to parallel while transparent
    par = 6'h15;
    mode = 1'b0;
    idle(3);
    expect_code(6'h15, "R10 parallel source selected");
    le = 1'b0;
    idle(6);
    par = 6'h2E;
    idle(4);
    expect_code(6'h15, "R6 hold after latch fall");

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule